// File: doc/BRIEF.md
# Multi-Rate Sample Word Interleaver

This block sits in front of a change-detecting compressor in a logic-capture path. Each input cycle can bring one sample of the probe channels. The block packs these samples into 16-bit event words. The packing depends on the selected capture rate, so faster rates give up channels in exchange for time resolution.

At the base rate, each word is one sample of all 16 channels. At double rate, two successive samples of 8 channels share one word, which covers a 20 ns period. At quadruple rate, four successive samples of 4 channels, 5 ns apart, share one word. Samples that share a word are bit-interleaved: the bits of one channel sit next to each other, not the samples in separate fields. The block emits each completed word with a one-cycle strobe. A change of rate drops any partly filled word, so a word never mixes rates.

Top module: `ilv_word_packer`

## Requirements
- R1: While reset is asserted and after it is released, `word_vld` is 0 and `word` is 0 until the first word completes.
- R2: The rate select is decoded as follows: 2'b00 is the base rate (1 sample per word), 2'b01 is double rate (2 samples), 2'b10 is quadruple rate (4 samples), and 2'b11 acts exactly like 2'b00.
- R3: At the base rate, every accepted sample produces `word` equal to `smp`, with `word_vld` high on the cycle after the sample is accepted.
- R4: At double rate, channel c (0..7, taken from `smp[c]`) of the s-th accepted sample (s = 0 earliest, 0..1) lands at `word` bit 2c+s. `word_vld` pulses once for every second accepted sample.
- R5: At quadruple rate, channel c (0..3, taken from `smp[c]`) of the s-th accepted sample (s = 0..3) lands at `word` bit 4c+s. `word_vld` pulses once for every fourth accepted sample.
- R6: At double rate, `smp[15:8]` has no effect on any word. At quadruple rate, `smp[15:4]` has no effect on any word.
- R7: A cycle with `in_vld` low neither adds a sample nor advances the word. Idle gaps of any length may fall between the samples of one word.
- R8: On any cycle where the decoded rate differs from the previous cycle's decoded rate, the partial word is discarded, whether or not `in_vld` is high. A sample accepted on that cycle becomes sample 0 of a new word.
- R9: A word appears exactly one cycle after its last sample is accepted. `word` then holds that value until the next word completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_sel | input | 2 | Rate select (00 base, 01 double, 10 quadruple, 11 as base) |
| in_vld | input | 1 | High when `smp` carries a sample |
| smp | input | 16 | One sample, bit n is channel n |
| word_vld | output | 1 | One-cycle strobe for a completed word |
| word | output | 16 | Interleaved event word, held between strobes |

## Verification
The bench drives upper channel bits with noise at the faster rates. A design that read the wrong channel lane would fill words with that noise. It switches the rate in the middle of a word, and also on an idle cycle. A design that kept the partial word would emit a mixed word, or emit one sample too early. Gaps inside words catch a slot counter that runs on idle cycles. Rate code 2'b11 and a long rotating sweep across all rates catch wrong bit positions and strobes that are missing or extra.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    RATE_X1 = 2'b00,
    RATE_X2 = 2'b01,
    RATE_X4 = 2'b10
  } rate_e;

  function automatic rate_e rate_decode(input logic [1:0] sel);
    rate_e r;
    case (sel)
      2'b01:   r = RATE_X2;
      2'b10:   r = RATE_X4;
      default: r = RATE_X1;
    endcase
    return r;
  endfunction

  function automatic int unsigned rate_slots(input rate_e r);
    int unsigned n;
    case (r)
      RATE_X2: n = 2;
      RATE_X4: n = 4;
      default: n = 1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ilv_slot_ctr.sv
module ilv_slot_ctr
  import ilv_pkg::*;
#(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              in_vld,
  output rate_e             rate_cur,
  output logic [SLOT_W-1:0] slot_eff,
  output logic              word_done
);

  rate_e             rate_q, rate_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              restart;
  logic              slot_en, rate_en;
  logic [SLOT_W-1:0] slot_last;

  always_comb begin
    rate_cur  = rate_decode(rate_sel);
    restart   = (rate_cur != rate_q);
    slot_eff  = restart ? '0 : slot_q;
    slot_last = SLOT_W'(rate_slots(rate_cur) - 1);
    word_done = in_vld && (slot_eff == slot_last);
    if (!in_vld)        slot_d = slot_eff;
    else if (word_done) slot_d = '0;
    else                slot_d = slot_eff + SLOT_W'(1);
    rate_d  = rate_cur;
    slot_en = in_vld || restart;
    rate_en = restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      rate_q <= RATE_X1;
    end else begin
      if (slot_en) slot_q <= slot_d;
      if (rate_en) rate_q <= rate_d;
    end
  end

  // R7/R8: the stored slot never reaches past the last slot of the stored rate
  p_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(slot_q) < rate_slots(rate_q)));

  // R8: a rate change leaves the counter at slot 0 or 1 of the new rate
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !in_vld) |=> (slot_q == '0));

endmodule

// File: rtl/ilv_lane_place.sv
module ilv_lane_place
  import ilv_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 2
) (
  input  rate_e             rate_cur,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] sample,
  output logic [WORD_W-1:0] placed,
  output logic [WORD_W-1:0] mask
);

  for (genvar j = 0; j < int'(WORD_W); j++) begin : g_bit
    localparam int CH2 = j / 2;
    localparam int SL2 = j % 2;
    localparam int CH4 = j / 4;
    localparam int SL4 = j % 4;
    logic hit;
    logic val;
    always_comb begin
      case (rate_cur)
        RATE_X2: begin
          hit = (slot == SLOT_W'(SL2));
          val = sample[CH2];
        end
        RATE_X4: begin
          hit = (slot == SLOT_W'(SL4));
          val = sample[CH4];
        end
        default: begin
          hit = (slot == '0);
          val = sample[j];
        end
      endcase
    end
    assign mask[j]   = hit;
    assign placed[j] = hit & val;
  end

endmodule

// File: rtl/ilv_word_acc.sv
module ilv_word_acc #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              word_done,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] placed,
  input  logic [WORD_W-1:0] mask,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] out_q, out_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] base;
  logic              acc_en, out_en;

  always_comb begin
    base   = (slot == '0) ? '0 : acc_q;
    acc_d  = (base & ~mask) | placed;
    out_d  = acc_d;
    vld_d  = word_done;
    acc_en = in_vld;
    out_en = word_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (acc_en) acc_q <= acc_d;
      if (out_en) out_q <= out_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = out_q;

  // R7: a word is only completed by an accepted sample
  p_done_needs_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(in_vld));

endmodule

// File: rtl/ilv_word_packer.sv
module ilv_word_packer
  import ilv_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MAX_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] smp,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

  rate_e             rate_cur;
  logic [SLOT_W-1:0] slot_eff;
  logic              word_done;
  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] mask;

  ilv_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .in_vld    (in_vld),
    .rate_cur  (rate_cur),
    .slot_eff  (slot_eff),
    .word_done (word_done)
  );

  ilv_lane_place #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_place (
    .rate_cur (rate_cur),
    .slot     (slot_eff),
    .sample   (smp),
    .placed   (placed),
    .mask     (mask)
  );

  ilv_word_acc #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .word_done (word_done),
    .slot      (slot_eff),
    .placed    (placed),
    .mask      (mask),
    .word_vld  (word_vld),
    .word      (word)
  );

  // R3: base rate passes the sample straight through one cycle later
  p_x1_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && rate_decode(rate_sel) == RATE_X1) |=> (word_vld && word == $past(smp)));

  // R4/R5: at multi-sample rates, strobes never come back to back while the rate holds
  p_pulse_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && rate_decode(rate_sel) != RATE_X1 && $stable(rate_sel)) |=> !word_vld);

  // R9: the word holds between strobes
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word));

endmodule

// File: tb/sim_ilv_word_packer.sv
module sim_ilv_word_packer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rate_sel;
  logic        in_vld;
  logic [15:0] smp;
  logic        word_vld;
  logic [15:0] word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_w[$];
  string       exp_tag[$];
  logic [15:0] last_exp = 16'h0;

  // model state
  int          m_rate;   // 1, 2 or 4 samples per word
  int          m_slot;
  logic [15:0] m_acc;

  always #10 clk = ~clk;

  ilv_word_packer u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .in_vld(in_vld),
    .smp(smp), .word_vld(word_vld), .word(word)
  );

  function automatic int slots_of(input logic [1:0] s);
    if (s == 2'b01) return 2;
    if (s == 2'b10) return 4;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [15:0] d, input logic [1:0] s, input string tag);
    int n;
    @(negedge clk);
    in_vld   = v;
    smp      = d;
    rate_sel = s;
    n = slots_of(s);
    if (n != m_rate) begin
      m_rate = n;
      m_slot = 0;
      m_acc  = 16'h0;
    end
    if (v) begin
      if (m_slot == 0) m_acc = 16'h0;
      for (int c = 0; c < 16 / n; c++)
        m_acc[c * n + m_slot] = d[c];
      if (m_slot == n - 1) begin
        exp_w.push_back(m_acc);
        exp_tag.push_back(tag);
        last_exp = m_acc;
        m_slot = 0;
      end else begin
        m_slot++;
      end
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && word_vld === 1'b1) begin
        if (exp_w.size() == 0) begin
          chk(1'b0, "R7 unexpected word strobe", word, 16'hxxxx);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_w.pop_front();
          t = exp_tag.pop_front();
          chk(word === e, t, word, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; in_vld = 1'b0; smp = 16'h0; rate_sel = 2'b00;
    m_rate = 1; m_slot = 0; m_acc = 16'h0;
    repeat (3) @(negedge clk);
    chk(word_vld === 1'b0, "R1 strobe in reset", {15'h0, word_vld}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_vld === 1'b0, "R1 strobe after reset", {15'h0, word_vld}, 16'h0);
    chk(word === 16'h0, "R1 word after reset", word, 16'h0);

    // R3 base rate, R2 code 11 behaves as base
    cyc(1, 16'hA5C3, 2'b00, "R3 base word");
    cyc(1, 16'h0001, 2'b00, "R3 base word");
    cyc(1, 16'hFFFF, 2'b11, "R2 code 11 as base");
    cyc(1, 16'h8000, 2'b11, "R2 code 11 as base");
    cyc(0, 16'h1234, 2'b00, "R7 idle");

    // R4 double rate with noise on upper channels (R6)
    cyc(1, 16'hAB55, 2'b01, "R4 double word");
    cyc(1, 16'h37AA, 2'b01, "R4 double word");
    cyc(1, 16'hFF0F, 2'b01, "R6 double ignores upper");
    cyc(1, 16'h00F0, 2'b01, "R6 double ignores upper");

    // R5 quadruple rate with gaps (R7) and noise (R6)
    cyc(1, 16'hFFF1, 2'b10, "R5 quad word");
    cyc(0, 16'hFFFF, 2'b10, "R7 gap");
    cyc(1, 16'h0002, 2'b10, "R5 quad word");
    cyc(0, 16'h000F, 2'b10, "R7 gap");
    cyc(0, 16'h000F, 2'b10, "R7 gap");
    cyc(1, 16'hABC4, 2'b10, "R5 quad word");
    cyc(1, 16'h0008, 2'b10, "R5 quad word");
    cyc(1, 16'h000F, 2'b10, "R6 quad ignores upper");
    cyc(1, 16'hF000, 2'b10, "R6 quad ignores upper");
    cyc(1, 16'hF005, 2'b10, "R6 quad ignores upper");
    cyc(1, 16'h000A, 2'b10, "R6 quad ignores upper");

    // R8 change mid-word with a sample on the change cycle
    cyc(1, 16'h000F, 2'b10, "R8 dropped partial");
    cyc(1, 16'h000F, 2'b10, "R8 dropped partial");
    cyc(1, 16'h0081, 2'b01, "R8 restart word");
    cyc(1, 16'h0042, 2'b01, "R8 restart word");
    // R8 change on an idle cycle
    cyc(1, 16'h00FF, 2'b01, "R8 dropped partial");
    cyc(0, 16'h0000, 2'b10, "R8 idle change");
    cyc(0, 16'h0000, 2'b01, "R8 idle change back");
    cyc(1, 16'h0011, 2'b01, "R8 restart after idle change");
    cyc(1, 16'h0022, 2'b01, "R8 restart after idle change");

    // R9 hold across idle cycles
    repeat (4) cyc(0, 16'hFFFF, 2'b01, "R9 idle");
    chk(word === last_exp, "R9 word held", word, last_exp);
    chk(word_vld === 1'b0, "R9 no strobe while idle", {15'h0, word_vld}, 16'h0);

    // sweep across rates
    lfsr = 16'hACE1;
    for (int k = 0; k < 120; k++) begin
      logic [1:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = 2'((k / 10) % 4);
      cyc(lfsr[0] | lfsr[5], lfsr, s, "R4 R5 sweep");
    end
    repeat (3) cyc(0, 16'h0, 2'b00, "tail");
    @(negedge clk);
    chk(exp_w.size() == 0, "R9 every expected word seen", 16'(exp_w.size()), 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule